// File: doc/BRIEF.md
# Cascaded Priority Interrupt Controller

This block collects interrupt requests from a set of primary channels and from a second, smaller group of channels. Each channel remembers a request in a pending flag until software clears it. A separate enable mask decides which pending flags count. The combined enabled request of the second group is fed in as primary channel 0. The enabled pending channels drive one interrupt line to the CPU, and a readable index names the channel that currently wins.

Software reaches the block through a 32-bit word register port. Enable masks are never written directly. One address sets enable bits and another clears them, so that no read-modify-write is needed. After it reads the winning index, software clears that channel's pending flag by writing a one to its bit. The block also holds one small map register per primary channel, which software normally loads with the channel's own number.

Top module: `casc_irq_ctrl`

## Requirements
- R1: A primary or secondary pending flag sets one clock after its request input goes from 0 to 1, and it stays set after the input returns to 0 until it is cleared by software.
- R2: Writing to the primary pending-clear word (0x10 for channels 0–31, 0x14 for channels 32–39, bit n%32) clears each flag whose bit is 1 and leaves the others as they are. A rising edge in the same cycle as a clear leaves the flag set. Reading either word returns the raw pending flags.
- R3: A 1 written to the enable-set word (0x20/0x24) sets that enable bit, and a 1 written to the enable-clear word (0x30/0x34) clears it. Zero bits change nothing. Reading either word returns that bank's enable mask, and bits 8–31 of bank 1 read as 0.
- R4: The status words 0x00/0x04 return the pending flags ANDed with the enables.
- R5: The index word 0x40 returns the lowest-numbered primary channel that is both pending and enabled, in bits 5:0, with the upper bits 0. It returns 0x3F when there is no such channel.
- R6: irq_o is 1 exactly while at least one primary channel is both pending and enabled.
- R7: The secondary group uses four words. 0x80 returns pending AND enable. 0x88 clears on a write of 1 and reads the raw pending flags. 0x90 sets enables, and 0x98 clears enables. Both 0x90 and 0x98 read back the secondary enable mask.
- R8: Primary channel 0 takes as its request the OR of the secondary pending-and-enabled flags. A rise of that OR latches primary pending bit 0 one clock later.
- R9: Word 0x200+4·n (n = 0..39) is a 6-bit read/write map register that resets to 0. Bits 31:6 read as 0.
- R10: After reset all pending flags, enables and map registers are 0. Addresses that are not listed read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prim_req_i | input | 39 | Request inputs of primary channels 1..39 (bit k is channel k) |
| sec_req_i | input | 32 | Request inputs of the secondary channels |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 12 | Byte address of the register word |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from addr_i |
| irq_o | output | 1 | Interrupt line to the CPU |

## Verification
The bench builds the block with its default sizes: 40 primary channels and 32 secondary channels. With these sizes the primary channels fill bank 0 and only partly fill bank 1, so the bench can check that the unused bank-1 bits read as zero. The secondary group is a full 32-bit word, so its top bit can be checked through the cascade into channel 0. The 6-bit index is wide enough that the empty value 0x3F never matches a real channel number. The bench runs a behavioural model alongside the design and compares irq_o and the read data for the addressed word on every clock.

// File: rtl/casc_irq_pkg.sv
package casc_irq_pkg;
  localparam int WORD_W     = 32;
  localparam int ADDR_W     = 12;
  // primary register types, banks 4 bytes apart
  localparam int OFS_STAT   = 'h000;
  localparam int OFS_PCLR   = 'h010;
  localparam int OFS_ESET   = 'h020;
  localparam int OFS_ECLR   = 'h030;
  localparam int OFS_PIDX   = 'h040;
  // secondary group
  localparam int OFS_SSTAT  = 'h080;
  localparam int OFS_SPCLR  = 'h088;
  localparam int OFS_SESET  = 'h090;
  localparam int OFS_SECLR  = 'h098;
  localparam int OFS_MAP    = 'h200;
endpackage

// File: rtl/casc_irq_bank.sv
module casc_irq_bank #(
  parameter int N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] pclr_i,
  input  logic [N-1:0] eset_i,
  input  logic [N-1:0] eclr_i,
  output logic [N-1:0] pend_o,
  output logic [N-1:0] en_o,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] act_o
);
  logic [N-1:0] prev_q;

  assign rise_o = req_i & ~prev_q;
  assign act_o  = pend_o & en_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      pend_o <= '0;
      en_o   <= '0;
    end else begin
      prev_q <= req_i;
      // a new edge beats a same-cycle clear
      pend_o <= (pend_o & ~pclr_i) | rise_o;
      en_o   <= (en_o | eset_i) & ~eclr_i;
    end
  end
endmodule

// File: rtl/casc_irq_prio_enc.sv
module casc_irq_prio_enc #(
  parameter int N     = 40,
  parameter int IDX_W = 6
) (
  input  logic [N-1:0]     act_i,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '1;
    for (int i = N - 1; i >= 0; i--) begin
      if (act_i[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/casc_irq_map_regs.sv
module casc_irq_map_regs #(
  parameter int N     = 40,
  parameter int IDX_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [IDX_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [IDX_W-1:0] rd_data_o
);
  logic [IDX_W-1:0] map_q [N];

  for (genvar g = 0; g < N; g++) begin : g_map
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                     map_q[g] <= '0;
      else if (wr_en_i && wr_idx_i == IDX_W'(g))        map_q[g] <= wr_data_i;
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < N; i++) begin
      if (rd_idx_i == IDX_W'(i)) rd_data_o = map_q[i];
    end
  end
endmodule

// File: rtl/casc_irq_ctrl.sv
module casc_irq_ctrl
  import casc_irq_pkg::*;
#(
  parameter int NUM_PRI = 40,
  parameter int NUM_SEC = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_PRI-1:1] prim_req_i,
  input  logic [NUM_SEC-1:0] sec_req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam int PBANKS = (NUM_PRI + WORD_W - 1) / WORD_W;
  localparam int PPAD   = PBANKS * WORD_W;
  localparam int IDX_W  = $clog2(NUM_PRI + 1);
  localparam logic [ADDR_W-3:0] MAP_WORD = (ADDR_W-2)'(OFS_MAP / 4);

  logic [NUM_PRI-1:0] prim_in, prim_pclr, prim_eset, prim_eclr;
  logic [NUM_PRI-1:0] prim_pend, prim_en, prim_rise, prim_act;
  logic [NUM_SEC-1:0] sec_pclr, sec_eset, sec_eclr;
  logic [NUM_SEC-1:0] sec_pend, sec_en, sec_rise, sec_act;
  logic               sec_any;
  logic [IDX_W-1:0]   prio_idx;
  logic [PPAD-1:0]    pend_pad, en_pad, act_pad;
  logic [ADDR_W-3:0]  map_word;
  logic               map_hit;
  logic [IDX_W-1:0]   map_rd;

  // write strobes per channel
  always_comb begin
    for (int c = 0; c < NUM_PRI; c++) begin
      prim_pclr[c] = we_i && addr_i == ADDR_W'(OFS_PCLR + 4 * (c / WORD_W)) && wdata_i[c % WORD_W];
      prim_eset[c] = we_i && addr_i == ADDR_W'(OFS_ESET + 4 * (c / WORD_W)) && wdata_i[c % WORD_W];
      prim_eclr[c] = we_i && addr_i == ADDR_W'(OFS_ECLR + 4 * (c / WORD_W)) && wdata_i[c % WORD_W];
    end
  end

  assign sec_pclr = (we_i && addr_i == ADDR_W'(OFS_SPCLR)) ? wdata_i[NUM_SEC-1:0] : '0;
  assign sec_eset = (we_i && addr_i == ADDR_W'(OFS_SESET)) ? wdata_i[NUM_SEC-1:0] : '0;
  assign sec_eclr = (we_i && addr_i == ADDR_W'(OFS_SECLR)) ? wdata_i[NUM_SEC-1:0] : '0;

  casc_irq_bank #(.N(NUM_SEC)) u_sec_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (sec_req_i),
    .pclr_i (sec_pclr),
    .eset_i (sec_eset),
    .eclr_i (sec_eclr),
    .pend_o (sec_pend),
    .en_o   (sec_en),
    .rise_o (sec_rise),
    .act_o  (sec_act)
  );

  assign sec_any = |sec_act;
  // cascade: secondary summary is the request of channel 0
  assign prim_in = {prim_req_i, sec_any};

  casc_irq_bank #(.N(NUM_PRI)) u_prim_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (prim_in),
    .pclr_i (prim_pclr),
    .eset_i (prim_eset),
    .eclr_i (prim_eclr),
    .pend_o (prim_pend),
    .en_o   (prim_en),
    .rise_o (prim_rise),
    .act_o  (prim_act)
  );

  casc_irq_prio_enc #(.N(NUM_PRI), .IDX_W(IDX_W)) u_prio (
    .act_i (prim_act),
    .idx_o (prio_idx)
  );

  assign irq_o = |prim_act;

  // map registers
  assign map_word = addr_i[ADDR_W-1:2] - MAP_WORD;
  assign map_hit  = addr_i[1:0] == 2'b00 && addr_i[ADDR_W-1:2] >= MAP_WORD
                    && map_word < (ADDR_W-2)'(NUM_PRI);

  casc_irq_map_regs #(.N(NUM_PRI), .IDX_W(IDX_W)) u_map (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (we_i && map_hit),
    .wr_idx_i  (map_word[IDX_W-1:0]),
    .wr_data_i (wdata_i[IDX_W-1:0]),
    .rd_idx_i  (map_word[IDX_W-1:0]),
    .rd_data_o (map_rd)
  );

  // read mux
  assign pend_pad = PPAD'(prim_pend);
  assign en_pad   = PPAD'(prim_en);
  assign act_pad  = PPAD'(prim_act);

  always_comb begin
    rdata_o = '0;
    for (int b = 0; b < PBANKS; b++) begin
      if (addr_i == ADDR_W'(OFS_STAT + 4 * b)) rdata_o = act_pad[b*WORD_W +: WORD_W];
      if (addr_i == ADDR_W'(OFS_PCLR + 4 * b)) rdata_o = pend_pad[b*WORD_W +: WORD_W];
      if (addr_i == ADDR_W'(OFS_ESET + 4 * b) ||
          addr_i == ADDR_W'(OFS_ECLR + 4 * b)) rdata_o = en_pad[b*WORD_W +: WORD_W];
    end
    if (addr_i == ADDR_W'(OFS_PIDX))  rdata_o = WORD_W'(prio_idx);
    if (addr_i == ADDR_W'(OFS_SSTAT)) rdata_o = WORD_W'(sec_act);
    if (addr_i == ADDR_W'(OFS_SPCLR)) rdata_o = WORD_W'(sec_pend);
    if (addr_i == ADDR_W'(OFS_SESET) || addr_i == ADDR_W'(OFS_SECLR)) rdata_o = WORD_W'(sec_en);
    if (map_hit) rdata_o = WORD_W'(map_rd);
  end
endmodule

// File: rtl/casc_irq_chk.sv
module casc_irq_chk #(
  parameter int NUM_PRI = 40,
  parameter int IDX_W   = $clog2(NUM_PRI + 1)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_PRI-1:0] pend_i,
  input logic [NUM_PRI-1:0] en_i,
  input logic [NUM_PRI-1:0] clr_i,
  input logic [NUM_PRI-1:0] rise_i,
  input logic [IDX_W-1:0]   idx_i,
  input logic               irq_i,
  input logic               sec_any_i
);
  localparam logic [IDX_W-1:0] NONE = '1;

  a_r1_pend_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(pend_i) & ~$past(clr_i) & ~pend_i) == '0);

  a_r1_edge_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rise_i) & ~pend_i) == '0);

  a_r5_winner_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_i != NONE |-> |(((pend_i & en_i) >> idx_i) & NUM_PRI'(1)));

  a_r5_winner_lowest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_i != NONE |-> ((pend_i & en_i) & ((NUM_PRI'(1) << idx_i) - NUM_PRI'(1))) == '0);

  a_r6_irq_has_winner: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> idx_i != NONE);

  a_r6_idle_no_winner: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_i |-> idx_i == NONE);

  a_r8_cascade_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sec_any_i) |=> pend_i[0]);
endmodule

bind casc_irq_ctrl casc_irq_chk #(.NUM_PRI(NUM_PRI)) u_casc_irq_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .pend_i    (prim_pend),
  .en_i      (prim_en),
  .clr_i     (prim_pclr),
  .rise_i    (prim_rise),
  .idx_i     (prio_idx),
  .irq_i     (irq_o),
  .sec_any_i (sec_any)
);

// File: tb/test_casc_irq_ctrl.sv
`timescale 1ns/1ps
module test_casc_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [39:1] preq = '0;
  logic [31:0] sreq = '0;
  logic        we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  // next values, applied at the falling edge
  logic [39:1] n_preq = '0;
  logic [31:0] n_sreq = '0;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  // behavioural model state
  bit [39:0] m_ppend = '0, m_pen = '0, m_pprev = '0;
  bit [31:0] m_spend = '0, m_sen = '0, m_sprev = '0;
  int        m_map [40];

  always #2.5 clk = ~clk;

  casc_irq_ctrl i_casc_irq_ctrl (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .prim_req_i (preq),
    .sec_req_i  (sreq),
    .we_i       (we),
    .addr_i     (addr),
    .wdata_i    (wdata),
    .rdata_o    (rdata),
    .irq_o      (irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(int a);
    bit [39:0] act = m_ppend & m_pen;
    if (a == 'h00) return act[31:0];
    if (a == 'h04) return {24'h0, act[39:32]};
    if (a == 'h10) return m_ppend[31:0];
    if (a == 'h14) return {24'h0, m_ppend[39:32]};
    if (a == 'h20 || a == 'h30) return m_pen[31:0];
    if (a == 'h24 || a == 'h34) return {24'h0, m_pen[39:32]};
    if (a == 'h40) begin
      for (int i = 0; i < 40; i++) if (act[i]) return i;
      return 'h3F;
    end
    if (a == 'h80) return m_spend & m_sen;
    if (a == 'h88) return m_spend;
    if (a == 'h90 || a == 'h98) return m_sen;
    if (a >= 'h200 && a < 'h2A0 && a % 4 == 0) return m_map[(a - 'h200) / 4];
    return 0;
  endfunction

  task automatic m_update();
    bit        s_any = |(m_spend & m_sen);
    bit [39:0] pin = {preq, s_any};
    bit [39:0] prise = pin & ~m_pprev;
    bit [31:0] srise = sreq & ~m_sprev;
    bit [39:0] pclr = '0, pset = '0, pecl = '0;
    bit [31:0] sclr = '0, sset = '0, secl = '0;
    int a = int'(addr);
    if (we) begin
      if (a == 'h10) pclr[31:0] = wdata;
      if (a == 'h14) pclr[39:32] = wdata[7:0];
      if (a == 'h20) pset[31:0] = wdata;
      if (a == 'h24) pset[39:32] = wdata[7:0];
      if (a == 'h30) pecl[31:0] = wdata;
      if (a == 'h34) pecl[39:32] = wdata[7:0];
      if (a == 'h88) sclr = wdata;
      if (a == 'h90) sset = wdata;
      if (a == 'h98) secl = wdata;
      if (a >= 'h200 && a < 'h2A0 && a % 4 == 0) m_map[(a - 'h200) / 4] = wdata & 'h3F;
    end
    m_pprev = pin;
    m_sprev = sreq;
    m_ppend = (m_ppend & ~pclr) | prise;
    m_spend = (m_spend & ~sclr) | srise;
    m_pen   = (m_pen | pset) & ~pecl;
    m_sen   = (m_sen | sset) & ~secl;
  endtask

  // one clock: drive, compare model and optional explicit value, advance
  task automatic cyc(bit w, int a, logic [31:0] d, bit has_exp, logic [31:0] exp, string req);
    @(negedge clk);
    preq = n_preq; sreq = n_sreq; we = w; addr = 12'(a); wdata = d;
    #1;
    chk("R6 irq_o vs model", {31'h0, irq}, {31'h0, |(m_ppend & m_pen)});
    chk({req, " rdata vs model"}, rdata, m_read(a));
    if (has_exp) chk(req, rdata, exp);
    @(posedge clk);
    m_update();
  endtask

  task automatic wr(int a, logic [31:0] d, string req);
    cyc(1'b1, a, d, 1'b0, 0, req);
  endtask

  task automatic rd(int a, logic [31:0] exp, string req);
    cyc(1'b0, a, 0, 1'b1, exp, req);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 40; i++) m_map[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;

    // R10 reset state
    rd('h40, 32'h3F, "R10 idx at reset");
    rd('h10, 0, "R10 pending at reset");
    rd('h20, 0, "R10 enables at reset");
    rd('h208, 0, "R10 map at reset");
    chk("R10 irq at reset", {31'h0, irq}, 0);
    rd('h100, 0, "R10 unmapped read");

    // R1 edge latch and hold
    n_preq[5] = 1'b1;
    rd('h10, 0, "R1 before edge");
    rd('h10, 32'h20, "R1 latched");
    n_preq[5] = 1'b0;
    rd('h10, 32'h20, "R1 held after drop");
    rd('h10, 32'h20, "R1 still held");
    rd('h40, 32'h3F, "R5 pending but not enabled");

    // R3 / R4 / R5 / R6
    wr('h20, 32'h20, "R3 set enable");
    rd('h30, 32'h20, "R3 mask via clear addr");
    rd('h40, 32'd5, "R5 single winner");
    chk("R6 irq asserted", {31'h0, irq}, 1);
    rd('h00, 32'h20, "R4 status");

    // R2 clear semantics
    wr('h10, 0, "R2 zero write");
    rd('h10, 32'h20, "R2 zeros no effect");
    wr('h10, 32'h20, "R2 clear ch5");
    rd('h10, 0, "R2 cleared");
    rd('h40, 32'h3F, "R5 none after clear");
    chk("R6 irq low", {31'h0, irq}, 0);

    // priority across banks
    n_preq[7] = 1'b1; n_preq[12] = 1'b1; n_preq[35] = 1'b1;
    wr('h24, 32'h08, "R3 set ch35");
    wr('h20, 32'h1020, "R3 set ch12 ch5");
    rd('h40, 32'd12, "R5 lowest enabled wins");
    rd('h14, 32'h08, "R2 bank1 raw pending");
    rd('h04, 32'h08, "R4 bank1 status");
    wr('h10, 32'h1000, "R2 clear ch12");
    rd('h40, 32'd35, "R5 bank1 winner");
    wr('h24, 32'hFFFF_FFFF, "R3 set all bank1");
    rd('h24, 32'hFF, "R3 unused bank1 bits zero");
    wr('h34, 32'hF7, "R3 clear bank1 except ch35");
    rd('h34, 32'h08, "R3 bank1 mask");

    // rise beats clear in the same cycle
    n_preq[20] = 1'b1;
    wr('h10, 32'h0010_0000, "R2 rise vs clear");
    rd('h10, 32'h0010_0080, "R2 rise wins");

    // secondary and cascade
    n_sreq[31] = 1'b1;
    rd('h88, 0, "R7 before sec edge");
    rd('h88, 32'h8000_0000, "R7 sec raw pending");
    rd('h80, 0, "R7 sec status masked");
    rd('h10, 32'h0010_0080, "R8 ch0 idle while sec masked");
    wr('h90, 32'h8000_0000, "R7 sec enable");
    rd('h98, 32'h8000_0000, "R7 sec mask readback");
    rd('h10, 32'h0010_0081, "R8 ch0 latched");
    wr('h20, 32'h1, "R3 enable ch0");
    rd('h40, 0, "R5 ch0 wins");
    rd('h80, 32'h8000_0000, "R7 sec status");
    wr('h88, 32'h8000_0000, "R7 sec clear");
    rd('h88, 0, "R7 sec cleared");
    rd('h10, 32'h0010_0081, "R1 ch0 held after cascade drop");
    wr('h10, 32'h1, "R2 clear ch0");
    rd('h40, 32'd35, "R5 back to ch35");
    wr('h98, 32'h8000_0000, "R7 sec disable");
    rd('h90, 0, "R7 sec mask clear");

    // R9 map registers
    for (int n = 0; n < 40; n++) wr('h200 + 4 * n, n, "R9 map write");
    for (int n = 0; n < 40; n++) rd('h200 + 4 * n, n, "R9 map read");
    wr('h29C, 32'hFFFF_FFFF, "R9 map wide write");
    rd('h29C, 32'h3F, "R9 map six bits");
    rd('h2A0, 0, "R10 past last map");

    // R10 unlisted writes ignored
    wr('h44, 32'hFFFF_FFFF, "R10 write unmapped");
    wr('h2A0, 32'hFFFF_FFFF, "R10 write past map");
    rd('h24, 32'h08, "R10 enables untouched");
    rd('h40, 32'd35, "R10 idx untouched");
    rd('h204, 32'd1, "R10 map untouched");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule